// File: doc/BRIEF.md
# Prescaled modulo-255 PWM generator

This block makes a single pulse-width modulated output from a system clock. A programmable divider produces one step pulse every 2×(N+1) clocks, where N is the prescale value. Each step advances an 8-bit period counter that runs from 0 to 254 and then returns to 0, so one period has 255 steps. The output is low from count 0 up to the compare value and high from the compare value to the end of the period. A compare value of 0 therefore keeps the output high, and a compare value of 255 keeps it low. Each counter wrap sets a sticky interrupt flag, which can be masked. Because the counter runs whether or not the pin is driven, the block can also serve as an interval timer.

Software writes the compare, prescale and control registers through a simple write strobe. Compare and prescale writes go to shadow copies. These copies move into the working registers only at a counter wrap, so no period ever mixes two settings. The pin output-enable follows the enable bit, and reset clears that bit. While the idle or power-down input is high, the output is forced high and the divider and counter hold their values.

Top module: `pwm255_gen`

## Requirements
- R1: The counter steps once every 2×(N+1) clocks (N = prescale value in use) through counts 0..254 and then returns to 0, so one wrap occurs every 510×(N+1) clocks.
- R2: Outside idle and power-down, the output is high exactly when the count is greater than or equal to the compare value in use. Over one full period the output is high for 2×(N+1)×(255−C) clocks.
- R3: Compare value 0 keeps the output high all the time. Compare value 255 keeps it low all the time.
- R4: Writes to the compare and prescale registers take effect only at the next counter wrap. Until that wrap, the output keeps following the old value.
- R5: After reset: output-enable 0, interrupt 0, count 0, compare 0, prescale 0, mask 0, so the output reads high.
- R6: The output-enable port equals control bit 0. Clearing that bit does not stop the divider or the counter, and wraps keep setting the flag.
- R7: While idle_i or pdown_i is 1, the output is 1 and the divider and counter hold their values. Counting resumes from the held state when both inputs return to 0.
- R8: A wrap sets a sticky flag. Writing control with bit 2 = 1 clears it, and a wrap in the same cycle wins over the clear. irq_o equals the flag AND NOT the mask (control bit 1).
- R9: Register addresses are 0 = compare, 1 = prescale, 2 = control (bit 0 enable, bit 1 mask, bit 2 clear strobe). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | W (8) | Write data |
| idle_i | input | 1 | Idle request: freeze counting, force output high |
| pdown_i | input | 1 | Power-down request: freeze counting, force output high |
| pwm_o | output | 1 | Modulated output |
| pwm_oe_o | output | 1 | Pin output-enable |
| irq_o | output | 1 | Wrap interrupt request |

## Verification
Some properties are checked on every cycle. The count never reaches 255, and the divider never passes its terminal value. The working compare and prescale values change only on a wrap, and the flag is set after every wrap. Extreme compare codes pin the output level, a masked flag never reaches irq_o, and the counter holds still while counting is suspended.

Other behaviours need the bench's scenarios. These are the exact period length for a given prescale value, the number of high clocks per period for compare values 1, 128 and 254, and the delayed effect of a compare write made in mid-period. The scenarios also cover flag stickiness and clearing, counting while the output is disabled, and correct resumption after idle and power-down.

// File: rtl/pwm255_pkg.sv
package pwm255_pkg;

  typedef enum logic [1:0] {
    REG_COMPARE  = 2'd0,
    REG_PRESCALE = 2'd1,
    REG_CONTROL  = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_CLR_BIT  = 2;

endpackage

// File: rtl/pwm255_prescaler.sv
module pwm255_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  localparam int DW = W + 1;

  logic [DW-1:0] div_q, div_d, term;

  // terminal value 2N+1 gives a step every 2(N+1) clocks
  always_comb begin
    term   = {reload_i, 1'b1};
    tick_o = run_i && (div_q == term);
  end

  always_comb begin
    div_d = div_q;
    if (run_i) begin
      if (tick_o) div_d = '0;
      else        div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= term); // R1

endmodule

// File: rtl/pwm255_counter.sv
module pwm255_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap_o = tick_i && (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (tick_i) begin
      if (wrap_o) cnt_d = '0;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != {W{1'b1}}); // R1

endmodule

// File: rtl/pwm255_regs.sv
module pwm255_regs
  import pwm255_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         wrap_i,
  output logic [W-1:0] cmp_o,
  output logic [W-1:0] pre_o,
  output logic         en_o,
  output logic         mask_o,
  output logic         flag_o
);
  reg_sel_e     sel;
  logic [W-1:0] cmp_sh_q, cmp_sh_d, pre_sh_q, pre_sh_d;
  logic [W-1:0] cmp_q, cmp_d, pre_q, pre_d;
  logic         en_q, en_d, mask_q, mask_d, flag_q, flag_d, clr;

  always_comb begin
    sel      = reg_sel_e'(wr_sel_i);
    cmp_sh_d = cmp_sh_q;
    pre_sh_d = pre_sh_q;
    en_d     = en_q;
    mask_d   = mask_q;
    clr      = 1'b0;
    if (wr_en_i) begin
      unique case (sel)
        REG_COMPARE:  cmp_sh_d = wr_data_i;
        REG_PRESCALE: pre_sh_d = wr_data_i;
        REG_CONTROL: begin
          en_d   = wr_data_i[CTL_EN_BIT];
          mask_d = wr_data_i[CTL_MASK_BIT];
          clr    = wr_data_i[CTL_CLR_BIT];
        end
        default: ;
      endcase
    end
    // working copies move only at the wrap
    cmp_d  = wrap_i ? cmp_sh_q : cmp_q;
    pre_d  = wrap_i ? pre_sh_q : pre_q;
    flag_d = wrap_i | (flag_q & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_sh_q <= '0;
      pre_sh_q <= '0;
      cmp_q    <= '0;
      pre_q    <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      cmp_sh_q <= cmp_sh_d;
      pre_sh_q <= pre_sh_d;
      cmp_q    <= cmp_d;
      pre_q    <= pre_d;
      en_q     <= en_d;
      mask_q   <= mask_d;
      flag_q   <= flag_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign pre_o  = pre_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;

  AST_ACTIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(cmp_q) && $stable(pre_q))); // R4
  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q); // R8

endmodule

// File: rtl/pwm255_gen.sv
module pwm255_gen #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         idle_i,
  input  logic         pdown_i,
  output logic         pwm_o,
  output logic         pwm_oe_o,
  output logic         irq_o
);
  logic [1:0]   sync_q;
  logic         rst_n, run, tick, wrap, en, mask, flag, level;
  logic [W-1:0] cnt, cmp_act, pre_act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n = sync_q[1];

  assign run = ~(idle_i | pdown_i);

  pwm255_prescaler #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .reload_i(pre_act), .tick_o(tick)
  );

  pwm255_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .cnt_o(cnt), .wrap_o(wrap)
  );

  pwm255_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wrap_i(wrap), .cmp_o(cmp_act), .pre_o(pre_act),
    .en_o(en), .mask_o(mask), .flag_o(flag)
  );

  always_comb begin
    level    = (cnt >= cmp_act);
    pwm_o    = ~run | level;
    pwm_oe_o = en;
    irq_o    = flag & ~mask;
  end

  AST_TOP_CODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run && (cmp_act == {W{1'b1}})) |-> !pwm_o); // R3
  AST_ZERO_CODE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmp_act == '0) |-> pwm_o); // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    mask |-> !irq_o); // R8

endmodule

// File: tb/pwm255_gen_test.sv
module pwm255_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       idle = 1'b0, pdown = 1'b0;
  logic       pwm, oe, irq;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit chk_on = 1'b0, done = 1'b0;
  int ctrl = 0;

  // behavioural reference state
  int m_div, m_cnt, m_cmp_sh, m_cmp, m_pre_sh, m_pre, m_en, m_mask, m_flag, m_rel;

  always #4 clk = ~clk;

  pwm255_gen #(.W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .idle_i(idle), .pdown_i(pdown),
    .pwm_o(pwm), .pwm_oe_o(oe), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_div = 0; m_cnt = 0; m_cmp_sh = 0; m_cmp = 0; m_pre_sh = 0; m_pre = 0;
    m_en = 0; m_mask = 0; m_flag = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rel = 0; m_reset();
    end else if (m_rel < 2) begin
      m_rel++; m_reset();
    end else begin
      bit run, tick, wrap, clr;
      int old_cmp, old_pre;
      run = !(idle || pdown);
      tick = run && (m_div == 2 * m_pre + 1);
      wrap = tick && (m_cnt == 254);
      old_cmp = m_cmp_sh; old_pre = m_pre_sh;
      clr = 1'b0;
      if (run) m_div = tick ? 0 : m_div + 1;
      if (tick) m_cnt = (m_cnt == 254) ? 0 : m_cnt + 1;
      if (wrap) begin m_cmp = old_cmp; m_pre = old_pre; end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_cmp_sh = wr_data;
          2'd1: m_pre_sh = wr_data;
          2'd2: begin m_en = wr_data[0]; m_mask = wr_data[1]; clr = wr_data[2]; end
          default: ;
        endcase
      end
      if (wrap) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (chk_on) begin
      int e_pwm, e_irq;
      e_pwm = (idle || pdown || (m_cnt >= m_cmp)) ? 1 : 0;
      e_irq = (m_flag && !m_mask) ? 1 : 0;
      check(pwm == e_pwm[0], "R2 pwm_o vs reference", pwm, e_pwm);
      check(oe == m_en[0], "R6 pwm_oe_o vs reference", oe, m_en);
      check(irq == e_irq[0], "R8 irq_o vs reference", irq, e_irq);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_wrap(input string req);
    int guard = 0;
    wr(2, ctrl | 4);
    while (!irq && guard < 5000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 5000) check(1'b0, req, guard, 0);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += pwm; end
  endtask

  initial begin
    #(150000 * 8);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int h, c0, bad;
    int codes[4] = '{1, 128, 254, 0};
    repeat (2) @(negedge clk);
    chk_on = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5 reset state
    check(pwm == 1'b1, "R5 pwm after reset", pwm, 1);
    check(oe == 1'b0, "R5 oe after reset", oe, 0);
    check(irq == 1'b0, "R5 irq after reset", irq, 0);

    ctrl = 1; wr(2, ctrl);
    check(oe == 1'b1, "R9 R6 enable via control bit 0", oe, 1);

    foreach (codes[i]) begin
      wr(0, codes[i]);
      wait_wrap("R2 wrap wait"); wait_wrap("R2 wrap wait");
      count_high(510, h);
      if (codes[i] == 0) check(h == 510, "R3 code 0 always high", h, 510);
      else check(h == 2 * (255 - codes[i]), "R2 high clocks per period", h, 2 * (255 - codes[i]));
    end

    // R4 compare write just after a wrap must not act before the next wrap
    wait_wrap("R4 wrap wait");
    wr(0, 255);
    count_high(400, h);
    check(h == 400, "R4 old compare kept until wrap", h, 400);
    wait_wrap("R3 wrap wait");
    count_high(510, h);
    check(h == 0, "R3 code 255 always low", h, 0);

    // R8 sticky flag, mask, clear
    repeat (600) @(negedge clk);
    check(irq == 1'b1, "R8 flag sticky", irq, 1);
    wr(2, 3);
    check(irq == 1'b0, "R8 mask hides flag", irq, 0);
    wr(2, 1);
    check(irq == 1'b1, "R8 flag still set after unmask", irq, 1);
    wr(2, 5);
    check(irq == 1'b0, "R8 write-one clear", irq, 0);

    // R1 period with prescale 1
    wr(1, 1);
    wait_wrap("R1 wrap wait");
    wait_wrap("R1 wrap wait"); c0 = cyc;
    wait_wrap("R1 wrap wait");
    check(cyc - c0 == 1020, "R1 period for prescale 1", cyc - c0, 1020);

    // R6 disabled output keeps counting
    ctrl = 0; wr(2, ctrl);
    check(oe == 1'b0, "R6 oe cleared", oe, 0);
    wait_wrap("R6 wrap wait"); c0 = cyc;
    wait_wrap("R6 wrap wait");
    check(cyc - c0 == 1020, "R6 period while disabled", cyc - c0, 1020);

    // R9 spare address ignored
    wr(3, 8'hFF);
    check(oe == 1'b0, "R9 spare write leaves enable", oe, 0);
    check(irq == 1'b1, "R9 spare write leaves flag", irq, 1);
    ctrl = 1; wr(2, ctrl);

    // R7 idle and power-down
    wait_wrap("R7 wrap wait");
    wr(2, ctrl | 4);
    @(negedge clk); idle = 1'b1;
    bad = 0;
    repeat (1200) begin @(negedge clk); if (!pwm || irq) bad++; end
    check(bad == 0, "R7 idle forces high and freezes", bad, 0);
    idle = 1'b0;
    repeat (50) @(negedge clk);
    pdown = 1'b1;
    bad = 0;
    repeat (1200) begin @(negedge clk); if (!pwm || irq) bad++; end
    check(bad == 0, "R7 power-down forces high and freezes", bad, 0);
    pdown = 1'b0;
    wait_wrap("R7 wrap wait"); c0 = cyc;
    wait_wrap("R7 wrap wait");
    check(cyc - c0 == 1020, "R7 period after resume", cyc - c0, 1020);

    done = 1'b1;
    chk_on = 1'b0;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule